// File: doc/BRIEF.md
# RAKE finger position searcher

This block picks the delay positions for a four-finger RAKE receiver from channel estimates as they are produced. Complex channel coefficients arrive one per cycle, delay by delay: for each delay index (quarter-chip resolution) the coefficients of all antenna-pair channels follow one another, channel 0 first. The block turns each coefficient into a cheap magnitude, adds these magnitudes over all channels of a delay, and so builds one shared power profile. The same delays serve every receive antenna. While the profile streams in, a sorted four-entry list keeps the strongest delays seen so far in this pass.

In the same pass the block forwards every coefficient whose delay equals one of the finger positions currently in force. Each one is tagged with the finger slot it belongs to and a two-bit set identifier, so a later stage can pair these coefficients with soft symbols despread at the same delays. No full set of estimates is stored. When the last coefficient of a pass arrives, the new finger list and the next set identifier take effect together.

Top module: `finger_searcher`

## Requirements
- R1: The profile value of a delay is the sum, over all NCH channels, of |re| + |im| of each coefficient. Coefficients are two's complement, so the most negative value counts with its full magnitude. No overflow occurs at full scale on every channel.
- R2: After a pass, the fing_pos slots hold the four delays with the largest profile values, strongest first. Slot k occupies bits [k*DW +: DW].
- R3: When profile values are equal, the earlier (lower) delay ranks above the later one.
- R4: The finger positions change only on the cycle that accepts the last coefficient of a pass, meaning delay NDELAY-1 and channel NCH-1. They hold their value during a pass.
- R5: fing_set advances by one, modulo 4, at each pass commit, in the same cycle as the new positions. It holds at all other times.
- R6: A valid coefficient whose delay equals the delay in finger slot k appears one cycle later with out_valid=1, unchanged re/im/channel, out_finger=k, and out_set equal to the set identifier in force when it was accepted. Other coefficients give out_valid=0.
- R7: After reset, slot k holds delay k (slots 0..3 hold 0,1,2,3), fing_set is 0 and out_valid is 0.
- R8: Cycles with coef_valid low change neither the profile, the ranking nor the outputs. Their cycle after produces out_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_valid | input | 1 | Coefficient present this cycle |
| coef_re | input | W | Real part, signed |
| coef_im | input | W | Imaginary part, signed |
| coef_delay | input | DW | Delay index of the coefficient |
| coef_chan | input | CW | Antenna-pair channel index |
| fing_pos | output | NF*DW | Committed finger delays, slot 0 strongest |
| fing_set | output | 2 | Identifier of the committed finger set |
| out_valid | output | 1 | Extracted coefficient present |
| out_re | output | W | Extracted real part |
| out_im | output | W | Extracted imaginary part |
| out_chan | output | CW | Channel of the extracted coefficient |
| out_finger | output | FW | Finger slot the coefficient belongs to |
| out_set | output | 2 | Set identifier tagging the coefficient |

## Verification
The bench targets equal profile values, both flat profiles and tied peaks. A design that compared with greater-or-equal would let later delays displace earlier ones. Full-scale negative coefficients on all channels at one delay expose a magnitude or accumulator that is too narrow, which would wrap and drop that delay from the list. Finger positions are sampled in mid-pass, and the tag of the last coefficient of a pass is checked, to catch a design that commits early or labels that coefficient with the new set. Idle cycles with garbage data are interleaved to catch a design that accumulates or forwards unqualified inputs.

// File: rtl/fsearch_pkg.sv
package fsearch_pkg;
  localparam int SET_W = 2;

  // |x| of a signed value; the result fits in the same width unsigned
  function automatic logic [15:0] abs16(input logic signed [15:0] x);
    return (x < 0) ? 16'(-x) : 16'(x);
  endfunction
endpackage

// File: rtl/fs_profile_acc.sv
module fs_profile_acc #(
  parameter int W      = 8,
  parameter int NCH    = 16,
  parameter int NDELAY = 32,
  localparam int CW    = $clog2(NCH),
  localparam int DW    = $clog2(NDELAY),
  localparam int PW    = W + 1 + CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_re,
  input  logic [W-1:0]  in_im,
  input  logic [DW-1:0] in_delay,
  input  logic [CW-1:0] in_chan,
  output logic          prof_valid,
  output logic [PW-1:0] prof_val,
  output logic          prof_first,
  output logic          prof_final
);
  import fsearch_pkg::*;

  logic [PW-1:0] acc_q;
  logic [PW-1:0] mag;
  logic [PW-1:0] sum;
  logic [15:0]   are, aim;

  always_comb begin
    are = abs16(16'(signed'(in_re)));
    aim = abs16(16'(signed'(in_im)));
    mag = PW'(are) + PW'(aim);
    sum = ((in_chan == '0) ? '0 : acc_q) + mag;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (in_valid) acc_q <= sum;
  end

  assign prof_valid = in_valid && (in_chan == CW'(NCH - 1));
  assign prof_val   = sum;
  assign prof_first = (in_delay == '0);
  assign prof_final = (in_delay == DW'(NDELAY - 1));
endmodule

// File: rtl/fs_peak_sort.sv
module fs_peak_sort #(
  parameter int NF     = 4,
  parameter int NDELAY = 32,
  parameter int PW     = 13,
  localparam int DW    = $clog2(NDELAY)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prof_valid,
  input  logic [PW-1:0]    prof_val,
  input  logic [DW-1:0]    prof_delay,
  input  logic             prof_first,
  input  logic             prof_final,
  output logic [NF*DW-1:0] fing_pos,
  output logic [1:0]       fing_set
);
  logic [DW-1:0] cand_pos [NF];
  logic [PW-1:0] cand_val [NF];
  logic [NF-1:0] cand_ok;
  logic [NF-1:0] base_ok;
  logic [NF-1:0] gt;
  logic [DW-1:0] ins_pos [NF];
  logic [PW-1:0] ins_val [NF];
  logic [NF-1:0] ins_ok;
  logic [NF*DW-1:0] fing_q;
  logic [1:0]       set_q;

  assign base_ok = prof_first ? '0 : cand_ok;

  // one compare stage per list entry; strict compare keeps the earlier delay on ties
  for (genvar k = 0; k < NF; k++) begin : g_stage
    assign gt[k] = !base_ok[k] || (prof_val > cand_val[k]);
    if (k == 0) begin : g_head
      always_comb begin
        if (gt[k]) begin
          ins_pos[k] = prof_delay; ins_val[k] = prof_val; ins_ok[k] = 1'b1;
        end else begin
          ins_pos[k] = cand_pos[k]; ins_val[k] = cand_val[k]; ins_ok[k] = base_ok[k];
        end
      end
    end else begin : g_tail
      always_comb begin
        if (!gt[k]) begin
          ins_pos[k] = cand_pos[k]; ins_val[k] = cand_val[k]; ins_ok[k] = base_ok[k];
        end else if (!gt[k-1]) begin
          ins_pos[k] = prof_delay; ins_val[k] = prof_val; ins_ok[k] = 1'b1;
        end else begin
          ins_pos[k] = cand_pos[k-1]; ins_val[k] = cand_val[k-1]; ins_ok[k] = base_ok[k-1];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cand_pos[k] <= '0;
        cand_val[k] <= '0;
        cand_ok[k]  <= 1'b0;
        fing_q[k*DW +: DW] <= DW'(k);
      end else if (prof_valid) begin
        cand_pos[k] <= ins_pos[k];
        cand_val[k] <= ins_val[k];
        cand_ok[k]  <= ins_ok[k];
        if (prof_final) fing_q[k*DW +: DW] <= ins_pos[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) set_q <= '0;
    else if (prof_valid && prof_final) set_q <= set_q + 2'd1;
  end

  assign fing_pos = fing_q;
  assign fing_set = set_q;
endmodule

// File: rtl/fs_tap_extract.sv
module fs_tap_extract #(
  parameter int W      = 8,
  parameter int NCH    = 16,
  parameter int NDELAY = 32,
  parameter int NF     = 4,
  localparam int CW    = $clog2(NCH),
  localparam int DW    = $clog2(NDELAY),
  localparam int FW    = $clog2(NF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     in_re,
  input  logic [W-1:0]     in_im,
  input  logic [DW-1:0]    in_delay,
  input  logic [CW-1:0]    in_chan,
  input  logic [NF*DW-1:0] fing_pos,
  input  logic [1:0]       fing_set,
  output logic             out_valid,
  output logic [W-1:0]     out_re,
  output logic [W-1:0]     out_im,
  output logic [CW-1:0]    out_chan,
  output logic [FW-1:0]    out_finger,
  output logic [1:0]       out_set
);
  logic          hit;
  logic [FW-1:0] hit_idx;

  // lowest slot wins; committed slots hold distinct delays
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int k = NF - 1; k >= 0; k--) begin
      if (fing_pos[k*DW +: DW] == in_delay) begin
        hit = 1'b1;
        hit_idx = FW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_re     <= '0;
      out_im     <= '0;
      out_chan   <= '0;
      out_finger <= '0;
      out_set    <= '0;
    end else begin
      out_valid <= in_valid && hit;
      if (in_valid && hit) begin
        out_re     <= in_re;
        out_im     <= in_im;
        out_chan   <= in_chan;
        out_finger <= hit_idx;
        out_set    <= fing_set;
      end
    end
  end
endmodule

// File: rtl/finger_searcher.sv
module finger_searcher #(
  parameter int W      = 8,
  parameter int NCH    = 16,
  parameter int NDELAY = 32,
  parameter int NF     = 4,
  localparam int CW    = $clog2(NCH),
  localparam int DW    = $clog2(NDELAY),
  localparam int FW    = $clog2(NF),
  localparam int PW    = W + 1 + CW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coef_valid,
  input  logic [W-1:0]     coef_re,
  input  logic [W-1:0]     coef_im,
  input  logic [DW-1:0]    coef_delay,
  input  logic [CW-1:0]    coef_chan,
  output logic [NF*DW-1:0] fing_pos,
  output logic [1:0]       fing_set,
  output logic             out_valid,
  output logic [W-1:0]     out_re,
  output logic [W-1:0]     out_im,
  output logic [CW-1:0]    out_chan,
  output logic [FW-1:0]    out_finger,
  output logic [1:0]       out_set
);
  logic          prof_valid, prof_first, prof_final;
  logic [PW-1:0] prof_val;

  fs_profile_acc #(.W(W), .NCH(NCH), .NDELAY(NDELAY)) u_acc (
    .clk(clk), .rst(rst), .in_valid(coef_valid), .in_re(coef_re), .in_im(coef_im),
    .in_delay(coef_delay), .in_chan(coef_chan), .prof_valid(prof_valid),
    .prof_val(prof_val), .prof_first(prof_first), .prof_final(prof_final)
  );

  fs_peak_sort #(.NF(NF), .NDELAY(NDELAY), .PW(PW)) u_sort (
    .clk(clk), .rst(rst), .prof_valid(prof_valid), .prof_val(prof_val),
    .prof_delay(coef_delay), .prof_first(prof_first), .prof_final(prof_final),
    .fing_pos(fing_pos), .fing_set(fing_set)
  );

  fs_tap_extract #(.W(W), .NCH(NCH), .NDELAY(NDELAY), .NF(NF)) u_ext (
    .clk(clk), .rst(rst), .in_valid(coef_valid), .in_re(coef_re), .in_im(coef_im),
    .in_delay(coef_delay), .in_chan(coef_chan), .fing_pos(fing_pos), .fing_set(fing_set),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_chan(out_chan),
    .out_finger(out_finger), .out_set(out_set)
  );
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
  parameter int NCH    = 16,
  parameter int NDELAY = 32,
  parameter int NF     = 4,
  localparam int CW    = $clog2(NCH),
  localparam int DW    = $clog2(NDELAY),
  localparam int FW    = $clog2(NF)
) (
  input logic             clk,
  input logic             rst,
  input logic             coef_valid,
  input logic [DW-1:0]    coef_delay,
  input logic [CW-1:0]    coef_chan,
  input logic [NF*DW-1:0] fing_pos,
  input logic [1:0]       fing_set,
  input logic             out_valid,
  input logic [FW-1:0]    out_finger
);
  logic commit;
  logic [NF*DW-1:0] prev_fing;
  logic [DW-1:0]    prev_delay;

  assign commit = coef_valid && coef_chan == CW'(NCH - 1) && coef_delay == DW'(NDELAY - 1);

  always_ff @(posedge clk) begin
    prev_fing  <= fing_pos;
    prev_delay <= coef_delay;
  end

  AST_FING_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(fing_pos)); // R4
  AST_SET_STEP: assert property (@(posedge clk) disable iff (rst)
    commit |=> fing_set == $past(fing_set) + 2'd1); // R5
  AST_SET_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(fing_set)); // R5
  AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (rst)
    !coef_valid |=> !out_valid); // R8
  AST_OUT_SLOT: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && out_valid |-> prev_fing[out_finger*DW +: DW] == prev_delay); // R6
endmodule

bind finger_searcher fs_checker #(.NCH(NCH), .NDELAY(NDELAY), .NF(NF)) u_fs_checker (
  .clk(clk), .rst(rst), .coef_valid(coef_valid), .coef_delay(coef_delay),
  .coef_chan(coef_chan), .fing_pos(fing_pos), .fing_set(fing_set),
  .out_valid(out_valid), .out_finger(out_finger)
);

// File: tb/test_finger_searcher.sv
module test_finger_searcher;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8, NCH = 16, NDELAY = 32, NF = 4;
  localparam int CW = $clog2(NCH), DW = $clog2(NDELAY), FW = $clog2(NF);

  logic clk = 0, rst = 1;
  logic coef_valid = 0;
  logic [W-1:0] coef_re = 0, coef_im = 0;
  logic [DW-1:0] coef_delay = 0;
  logic [CW-1:0] coef_chan = 0;
  logic [NF*DW-1:0] fing_pos;
  logic [1:0] fing_set, out_set;
  logic out_valid;
  logic [W-1:0] out_re, out_im;
  logic [CW-1:0] out_chan;
  logic [FW-1:0] out_finger;

  int n_chk = 0, n_fail = 0;
  int re_t [NDELAY][NCH];
  int im_t [NDELAY][NCH];
  int exp_f [NF];
  int exp_set = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  finger_searcher #(.W(W), .NCH(NCH), .NDELAY(NDELAY), .NF(NF)) i_finger_searcher (
    .clk(clk), .rst(rst), .coef_valid(coef_valid), .coef_re(coef_re), .coef_im(coef_im),
    .coef_delay(coef_delay), .coef_chan(coef_chan), .fing_pos(fing_pos), .fing_set(fing_set),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_chan(out_chan),
    .out_finger(out_finger), .out_set(out_set)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int absi(input int x);
    return x < 0 ? -x : x;
  endfunction

  task automatic check_fingers(input string req);
    for (int k = 0; k < NF; k++)
      check(req, int'(fing_pos[k*DW +: DW]), exp_f[k]);
    check({req, " set"}, int'(fing_set), exp_set);
  endtask

  // expected output for a coefficient accepted one cycle earlier
  task automatic check_out(input bit pv, input int d, input int c);
    int slot = -1;
    for (int k = 0; k < NF; k++) if (pv && exp_f[k] == d && slot < 0) slot = k;
    check("R6/R8 out_valid", int'(out_valid), slot >= 0 ? 1 : 0);
    if (slot >= 0 && out_valid) begin
      check("R6 re", int'(signed'(out_re)), re_t[d][c]);
      check("R6 im", int'(signed'(out_im)), im_t[d][c]);
      check("R6 chan", int'(out_chan), c);
      check("R6 finger", int'(out_finger), slot);
      check("R6 set", int'(out_set), exp_set);
    end
  endtask

  function automatic int pick(input int pat, input int d, input int c, input bit im);
    case (pat)
      0: return im ? ((d*5 + c) % 17) - 8 : ((d*7 + c*3) % 23) - 11;
      1: return im ? 0 : 1;
      2: return im ? 0 : ((d == 9 || d == 20) ? 5 : (d == 3 || d == 30) ? 4 : 1);
      3: begin
        if (d == 12) return -128;
        if (d == 31 && c == 5) return -128;
        if (d == 17) return im ? -1 : 0;
        return 0;
      end
      default: return im ? -((d + c*7) % 13) : ((d*11 + c*5) % 29) - 14;
    endcase
  endfunction

  // one full profile pass; gaps inserts idle cycles with garbage data
  task automatic run_pass(input int pat, input bit gaps, input string req);
    int prof [NDELAY];
    bit used [NDELAY];
    bit pv = 0;
    int pd = 0, pc = 0;
    for (int d = 0; d < NDELAY; d++) begin
      prof[d] = 0;
      used[d] = 0;
      for (int c = 0; c < NCH; c++) begin
        re_t[d][c] = pick(pat, d, c, 0);
        im_t[d][c] = pick(pat, d, c, 1);
        prof[d] += absi(re_t[d][c]) + absi(im_t[d][c]);
      end
    end
    for (int d = 0; d < NDELAY; d++) begin
      for (int c = 0; c < NCH; c++) begin
        @(negedge clk);
        check_out(pv, pd, pc);
        if (d == NDELAY/2 && c == 0) check_fingers("R4 mid-pass hold");
        if (gaps && ((d + c) % 5 == 0)) begin
          coef_valid = 0;
          coef_re = 8'h80; coef_im = 8'h80;
          coef_delay = DW'(exp_f[0]); coef_chan = CW'(c);
          @(negedge clk);
          check_out(0, 0, 0);
        end
        coef_valid = 1;
        coef_re = W'(re_t[d][c]);
        coef_im = W'(im_t[d][c]);
        coef_delay = DW'(d);
        coef_chan = CW'(c);
        pv = 1; pd = d; pc = c;
      end
    end
    @(negedge clk);
    check_out(pv, pd, pc);
    coef_valid = 0;
    for (int k = 0; k < NF; k++) begin
      int best = -1;
      for (int d = 0; d < NDELAY; d++)
        if (!used[d] && (best < 0 || prof[d] > prof[best])) best = d;
      used[best] = 1;
      exp_f[k] = best;
    end
    exp_set = (exp_set + 1) % 4;
    check_fingers(req);
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int k = 0; k < NF; k++) exp_f[k] = k;
    exp_set = 0;
    @(negedge clk);
    check_fingers("R7 reset");
    check("R7 out_valid", int'(out_valid), 0);
  endtask

  task automatic t_mixed;     run_pass(0, 0, "R1/R2 mixed signs"); endtask
  task automatic t_flat;      run_pass(1, 0, "R3 flat profile"); endtask
  task automatic t_tied;      run_pass(2, 0, "R3 tied peaks"); endtask
  task automatic t_fullscale; run_pass(3, 0, "R1 full scale"); endtask
  task automatic t_gaps;      run_pass(4, 1, "R8 idle cycles"); endtask

  task automatic t_wrap;
    run_pass(0, 0, "R5 wrap a");
    run_pass(4, 0, "R5 wrap b");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_mixed();
    t_flat();
    t_tied();
    t_fullscale();
    t_gaps();
    t_wrap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule